// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block gathers the data bytes of one serial-memory write transaction into a 32-byte page latch. It then writes them into a byte-wide memory array during a single self-timed busy window. A bus front end loads the starting word address, streams data bytes in, and then signals either the end of the transaction (a valid STOP) or its abandonment (an abort, which the front end also raises for a repeated START). Each accepted byte lands in the page slot selected by the low five bits of a shared address counter. Only those five bits advance, so a long burst wraps inside the page and later bytes replace earlier ones.

On a STOP that follows at least one byte, the block raises `busy` and starts a countdown of `COMMIT_CYCLES` system clocks, which stands in for the program time. During that window it scans the 32 slots in ascending order and drives one memory write per clock for every slot loaded in the transaction. Slots that were not loaded are skipped. When the count runs out, `busy` falls and the slot-valid mask is cleared.

Byte input is a valid/ready stream. A byte transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while `busy` is high and in any cycle where `addr_set`, `stop_seen` or `txn_abort` is asserted. The source must hold `in_valid` and `in_data` until the transfer completes. All other pins are plain single-cycle strobes or levels.

Top module: `page_commit_buffer`

## Requirements
- R1: The page holds 32 one-byte slots. One transaction may load from 1 to 32 distinct slots, and all of them are written to the array inside one busy window, at address {upper counter bits, slot}.
- R2: Each accepted byte increments only bits [4:0] of `cur_addr`, and slot 31 wraps to slot 0. Bits above bit 4 do not change during loading.
- R3: When more than 32 bytes are loaded before STOP, a slot that is loaded again holds the most recent byte, and only that byte is written to the array.
- R4: A commit starts only on `stop_seen` when at least one byte is latched and `busy` is low. A STOP with no latched bytes leaves `busy` low and produces no array writes.
- R5: `busy` rises on the clock edge that samples the qualifying STOP and stays high for exactly COMMIT_CYCLES+1 clock cycles.
- R6: After a commit, `cur_addr` equals the address of the last loaded byte plus one, with the increment confined to bits [4:0].
- R7: Array slots not loaded in the transaction keep their contents. The valid mask is empty after the busy window, so a following STOP with no new bytes starts no commit.
- R8: `txn_abort` while `busy` is low discards all latched bytes. A following STOP then starts no commit and writes nothing.
- R9: While `busy` is high, `in_ready` is low and `addr_set` is ignored. Bytes offered in that window are never written, and `cur_addr` does not move.
- R10: After reset, `busy` = 0, `in_ready` = 1, `mem_we` = 0 and `cur_addr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_set | input | 1 | Load `addr_val` into the address counter (ignored while busy) |
| addr_val | input | AW | Starting word address |
| in_valid | input | 1 | Data byte offered |
| in_data | input | 8 | Data byte |
| in_ready | output | 1 | Byte accepted this cycle if `in_valid` is high |
| stop_seen | input | 1 | One-cycle pulse: valid STOP ending a write transaction |
| txn_abort | input | 1 | One-cycle pulse: discard the latched transaction |
| busy | output | 1 | Commit window in progress |
| cur_addr | output | AW | Shared address counter |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The in-RTL assertions check the following on every cycle: the upper address bits hold and the low bits step by one on each accepted byte; `busy` holds while the countdown is non-zero; no byte is accepted and no address load takes effect while `busy` is high; every array write falls inside a busy window; a busy window opens only over a non-empty mask; and the mask is empty once the window closes. Only the bench scenarios can show the rest. This covers the exact length of the busy window, the cycle in which it opens, the number and content of array writes per commit, the last-byte-wins effect of a wrapped burst, that untouched slots are preserved, and that an abort leaves the array unchanged.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef logic [7:0] byte_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/pwb_addr_ctr.sv
module pwb_addr_ctr #(
  parameter int AW = 13,
  parameter int OW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [AW-1:0] set_val,
  input  logic          step_en,
  output logic [AW-1:0] addr
);
  logic [OW-1:0] low_next;

  always_comb low_next = addr[OW-1:0] + OW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)       addr <= '0;
    else if (set_en)  addr <= set_val;
    else if (step_en) addr <= {addr[AW-1:OW], low_next};
  end

  // R2: a step keeps the page bits and advances the in-page offset by one
  assert_page_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !set_en) |=>
      (addr[AW-1:OW] == $past(addr[AW-1:OW])) &&
      (addr[OW-1:0] == $past(addr[OW-1:0]) + OW'(1)));
endmodule

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
  parameter int PB = 32,
  parameter int OW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [OW-1:0]  wr_slot,
  input  pwb_pkg::byte_t wr_data,
  input  logic           clr,
  input  logic [OW-1:0]  rd_slot,
  output pwb_pkg::byte_t rd_data,
  output logic [PB-1:0]  mask
);
  pwb_pkg::byte_t slot_q [PB];

  for (genvar g = 0; g < PB; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_slot == OW'(g));

    always_ff @(posedge clk) begin
      if (hit) slot_q[g] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)   mask[g] <= 1'b0;
      else if (clr) mask[g] <= 1'b0;
      else if (hit) mask[g] <= 1'b1;
    end
  end

  assign rd_data = slot_q[rd_slot];

  // R1: a stored byte marks its slot as pending
  assert_slot_marked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> mask[$past(wr_slot)]);
endmodule

// File: rtl/pwb_commit_timer.sv
module pwb_commit_timer #(
  parameter int CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = pwb_pkg::cnt_width(CYC);

  logic [CW-1:0] tmr;

  assign done = busy && (tmr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tmr  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        tmr  <= CW'(CYC);
      end
    end else if (tmr == '0) begin
      busy <= 1'b0;
    end else begin
      tmr <= tmr - CW'(1);
    end
  end

  // R5: the window cannot close while the count is non-zero
  assert_busy_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmr != '0) |=> busy);
  // R5: an expired count always closes the window in the next clock
  assert_busy_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer #(
  parameter int AW            = 13,
  parameter int PAGE_BYTES    = 32,
  parameter int COMMIT_CYCLES = 500
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addr_set,
  input  logic [AW-1:0]        addr_val,
  input  logic                 in_valid,
  input  logic [7:0]           in_data,
  output logic                 in_ready,
  input  logic                 stop_seen,
  input  logic                 txn_abort,
  output logic                 busy,
  output logic [AW-1:0]        cur_addr,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [7:0]           mem_wdata
);
  localparam int OW = $clog2(PAGE_BYTES);
  localparam int SW = OW + 1;

  initial begin
    if (COMMIT_CYCLES + 1 < PAGE_BYTES)
      $error("COMMIT_CYCLES too short to scan the page");
  end

  logic                  accept;
  logic                  set_ok;
  logic                  commit_go;
  logic                  done;
  logic                  latch_clr;
  logic [PAGE_BYTES-1:0] mask;
  logic [SW-1:0]         scan;
  logic [OW-1:0]         scan_slot;
  logic                  scan_live;
  pwb_pkg::byte_t        rd_byte;

  assign in_ready  = !busy && !stop_seen && !txn_abort && !addr_set;
  assign accept    = in_valid && in_ready;
  assign set_ok    = addr_set && !busy;
  assign commit_go = stop_seen && !txn_abort && !busy && (|mask);
  assign latch_clr = (txn_abort && !busy) || done;

  pwb_addr_ctr #(.AW(AW), .OW(OW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (set_ok),
    .set_val (addr_val),
    .step_en (accept),
    .addr    (cur_addr)
  );

  pwb_page_latch #(.PB(PAGE_BYTES), .OW(OW)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept),
    .wr_slot (cur_addr[OW-1:0]),
    .wr_data (in_data),
    .clr     (latch_clr),
    .rd_slot (scan_slot),
    .rd_data (rd_byte),
    .mask    (mask)
  );

  pwb_commit_timer #(.CYC(COMMIT_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (commit_go),
    .busy  (busy),
    .done  (done)
  );

  // slot scan runs once per busy window, one slot per clock
  always_ff @(posedge clk) begin
    if (!rst_n)                scan <= '0;
    else if (commit_go)        scan <= '0;
    else if (busy && scan_live) scan <= scan + SW'(1);
  end

  assign scan_slot = scan[OW-1:0];
  assign scan_live = !scan[OW];

  assign mem_we    = busy && scan_live && mask[scan_slot];
  assign mem_addr  = {cur_addr[AW-1:OW], scan_slot};
  assign mem_wdata = rd_byte;

  // R9: no byte transfer while the commit window is open
  assert_no_load_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  // R9: the address counter is frozen during the window
  assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_addr));
  // R4: array writes only happen inside a busy window
  assert_write_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R4: a window opens only over a non-empty mask
  assert_commit_needs_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mask != '0));
  // R7: the mask is empty once the window has closed
  assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mask == '0));
endmodule

// File: tb/sim_page_commit_buffer.sv
module sim_page_commit_buffer;
  localparam int AW  = 10;
  localparam int PB  = 32;
  localparam int CYC = 40;
  localparam int NV  = 6;
  localparam int MEMSZ = 1 << AW;

  localparam int VEC_ADDR [NV] = '{'h000, 'h05A, 'h3F0, 'h120, 'h2C3, 'h1FF};
  localparam int VEC_N    [NV] = '{1,     4,     20,    32,    40,    2};
  localparam int VEC_SEED [NV] = '{'h11,  'h40,  'h80,  'hC0,  'h05,  'h70};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          addr_set = 1'b0;
  logic [AW-1:0] addr_val = '0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_ready;
  logic          stop_seen = 1'b0;
  logic          txn_abort = 1'b0;
  logic          busy;
  logic [AW-1:0] cur_addr;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;

  always #10 clk = ~clk;

  page_commit_buffer #(.AW(AW), .PAGE_BYTES(PB), .COMMIT_CYCLES(CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_set(addr_set), .addr_val(addr_val),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .stop_seen(stop_seen), .txn_abort(txn_abort), .busy(busy),
    .cur_addr(cur_addr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  logic [7:0] dut_mem [MEMSZ];
  logic [7:0] exp_mem [MEMSZ];
  int wr_cnt = 0;
  int busy_cnt = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (mem_we) begin
      dut_mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (busy) busy_cnt <= busy_cnt + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    finished = 1;
    $finish;
  endtask

  task automatic clear_counts();
    @(negedge clk);
    wr_cnt = 0;
    busy_cnt = 0;
  endtask

  task automatic set_addr(input logic [AW-1:0] a);
    @(negedge clk);
    addr_set = 1'b1; addr_val = a;
    @(negedge clk);
    addr_set = 1'b0;
  endtask

  task automatic load_byte(input logic [7:0] d);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_seen = 1'b1;
    @(negedge clk);
    stop_seen = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  // full transaction with bench-side expectation of memory and address
  task automatic run_txn(input int a, input int n, input int seed, output int exp_cur);
    int lo;
    bit [PB-1:0] hit;
    hit = '0;
    lo = a % PB;
    clear_counts();
    set_addr(AW'(a));
    for (int i = 0; i < n; i++) begin
      load_byte(8'(seed + i));
      exp_mem[(a / PB) * PB + ((lo + i) % PB)] = 8'(seed + i);
      hit[(lo + i) % PB] = 1'b1;
    end
    pulse_stop();
    wait_idle();
    exp_cur = (a / PB) * PB + ((lo + n) % PB);
    check("R1 write count", wr_cnt, $countones(hit));
    check("R5 busy window length", busy_cnt, CYC + 1);
    check("R6 address after commit", int'(cur_addr), exp_cur);
  endtask

  task automatic check_page(input string req, input int a);
    int bad;
    int base;
    bad = 0;
    base = (a / PB) * PB;
    for (int s = 0; s < PB; s++)
      if (dut_mem[base + s] !== exp_mem[base + s]) bad++;
    check(req, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    int ec;
    for (int i = 0; i < MEMSZ; i++) begin
      dut_mem[i] = 8'h00;
      exp_mem[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 busy", int'(busy), 0);
    check("R10 in_ready", int'(in_ready), 1);
    check("R10 mem_we", int'(mem_we), 0);
    check("R10 cur_addr", int'(cur_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R1, R2, R3 (40-byte wrap), R6, R7 (untouched slots)
    for (int v = 0; v < NV; v++) begin
      run_txn(VEC_ADDR[v], VEC_N[v], VEC_SEED[v], ec);
      check_page("R1 R2 R3 R7 page contents", VEC_ADDR[v]);
    end

    // R5: busy rises on the edge sampling STOP
    clear_counts();
    set_addr(AW'('h240));
    load_byte(8'h5A);
    exp_mem['h240] = 8'h5A;
    stop_seen = 1'b1;
    @(posedge clk);
    #1;
    check("R5 busy one edge after STOP", int'(busy), 1);
    @(negedge clk);
    stop_seen = 1'b0;

    // R9: loads and address sets ignored during the window
    @(negedge clk);
    check("R9 in_ready low while busy", int'(in_ready), 0);
    in_valid = 1'b1; in_data = 8'hEE;
    addr_set = 1'b1; addr_val = AW'('h000);
    repeat (5) @(negedge clk);
    in_valid = 1'b0; addr_set = 1'b0;
    wait_idle();
    check("R9 cur_addr not moved", int'(cur_addr), 'h241);
    check_page("R9 no stray byte written", 'h240);

    // R7 / R4: mask cleared, so a bare STOP starts nothing
    clear_counts();
    pulse_stop();
    repeat (4) @(negedge clk);
    check("R7 R4 no commit on empty mask", busy_cnt, 0);
    check("R4 no writes on empty STOP", wr_cnt, 0);

    // R8: abort discards latched bytes
    clear_counts();
    set_addr(AW'('h300));
    load_byte(8'hA0);
    load_byte(8'hA1);
    load_byte(8'hA2);
    txn_abort = 1'b1;
    @(negedge clk);
    txn_abort = 1'b0;
    pulse_stop();
    repeat (4) @(negedge clk);
    check("R8 no busy after abort", busy_cnt, 0);
    check("R8 no writes after abort", wr_cnt, 0);
    check_page("R8 array unchanged", 'h300);

    // R2: a load after abort still uses the advanced offset within the page
    check("R2 page bits fixed", int'(cur_addr), 'h303);

    summary();
  end
endmodule